// File: doc/BRIEF.md
# Multichannel Ramp Converter Sequencer

This block is the digital side of a single-slope converter shared by many channels. When a start command arrives while it is idle, it raises a ramp-enable output for the analog ramp generator and runs one counter on the fast clock. Every channel has its own comparator input. The first rising edge on a channel's comparator during a conversion stores the current count, in Gray code, into that channel's 12-bit result register.

There are 32 result registers. Indices 0 to 15 hold charge values and indices 16 to 31 hold fine-time values. The length of a conversion follows from the resolution chosen at start: 8, 10 or 12 bits. A conversion of N bits lasts 2^N counter clocks, which is 102.4 µs at 12 bits with a 40 MHz counter clock. At the terminal count the ramp enable drops and a one-cycle done pulse follows. A channel that never fired then receives the full-scale code. Results are read through a combinational address/data port.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After reset, ramp_en_o and done_o are 0 and every result register reads 0.
- R2: A start_i sampled high while idle raises ramp_en_o at the next edge and starts the count at 0. The resolution is latched at that moment: res_sel_i 0 gives 8 bits, 1 gives 10 bits, and 2 or 3 give 12 bits.
- R3: ramp_en_o stays high for exactly 2^N cycles. done_o is high for exactly one cycle, the first cycle in which ramp_en_o is low again.
- R4: A rising edge on cmp_i[k] (high now, low in the previous cycle) that is seen while the count is c stores c XOR (c>>1) into register k. Register k is read at rd_addr_i = k.
- R5: Only the first rising edge of a channel in a conversion is stored. Later edges leave the register unchanged.
- R6: A channel with no rising edge during a conversion holds Gray(2^N-1) at done. That value is 0x080 for 8 bits, 0x200 for 10 bits and 0x800 for 12 bits.
- R7: All registers are cleared to 0 at start. Bits 11 down to N of every result are always 0.
- R8: start_i is ignored while a conversion is running. It neither restarts nor lengthens the conversion.
- R9: A comparator already high when the conversion starts, and staying high, is not an edge. That channel gets the full-scale code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start request |
| res_sel_i | input | 2 | Resolution select |
| cmp_i | input | 32 | Comparator levels, one per channel |
| rd_addr_i | input | 5 | Result register index |
| ramp_en_o | output | 1 | Ramp enable for the analog ramp |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| rd_data_o | output | 12 | Gray-coded result of the addressed register |

## Verification
The sampling times are as follows:
- The ramp enable appears one edge after start is sampled.
- A comparator edge driven while the count is c is stored at the next edge. The stored value is visible in the window where the count is c+1.
- The done pulse and the full-scale fill both appear one edge after the count reaches 2^N-1.

The bench drives inputs on the falling edge. It tracks the count as the number of windows since start and samples outputs one time unit later. This lets it predict each stored code exactly and check the ramp length, the done pulse and the read-back values in the cycle where they are due.

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int CH_PER_KIND = 16,
  parameter int MAX_W = 12,
  parameter int NCH = 2 * CH_PER_KIND,
  parameter int AW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       res_sel_i,
  input  logic [NCH-1:0]   cmp_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic             ramp_en_o,
  output logic             done_o,
  output logic [MAX_W-1:0] rd_data_o
);

  logic             run_q, done_q;
  logic [1:0]       res_q;
  logic [MAX_W-1:0] cnt_q, term;
  logic [NCH-1:0]   cmp_q, hit_q;
  logic [MAX_W-1:0] mem [NCH];

  always_comb begin
    case (res_q)
      2'd0:    term = MAX_W'((1 << (MAX_W - 4)) - 1);
      2'd1:    term = MAX_W'((1 << (MAX_W - 2)) - 1);
      default: term = {MAX_W{1'b1}};
    endcase
  end

  wire             launch   = !run_q && start_i;
  wire             last     = run_q && (cnt_q == term);
  wire [NCH-1:0]   fire     = cmp_i & ~cmp_q & ~hit_q & {NCH{run_q}};
  wire [MAX_W-1:0] cnt_gray = cnt_q ^ (cnt_q >> 1);
  wire [MAX_W-1:0] fs_gray  = term ^ (term >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      res_q  <= 2'd0;
      cnt_q  <= '0;
      cmp_q  <= '0;
      hit_q  <= '0;
    end else begin
      cmp_q  <= cmp_i;
      done_q <= last;
      if (launch) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        res_q <= res_sel_i;
        hit_q <= '0;
      end else if (run_q) begin
        cnt_q <= cnt_q + 1'b1;
        hit_q <= hit_q | fire;
        if (last) run_q <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 mem[g] <= '0;
      else if (launch)            mem[g] <= '0;
      else if (fire[g])           mem[g] <= cnt_gray;
      else if (last && !hit_q[g]) mem[g] <= fs_gray;
    end

    AST_HELD_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && hit_q[g]) |=> $stable(mem[g])); // R5
  end

  assign ramp_en_o = run_q;
  assign done_o    = done_q;
  assign rd_data_o = mem[rd_addr_i];

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3
  AST_DONE_AFTER_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(ramp_en_o) && !ramp_en_o)); // R3
  AST_RAMP_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ramp_en_o) |-> done_o); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en_o |-> (cnt_q <= term)); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en_o && !last) |=> (ramp_en_o && cnt_q == $past(cnt_q) + 1'b1)); // R8
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q == 2'd0) |-> (rd_data_o[MAX_W-1:MAX_W-4] == '0)); // R7

endmodule

// File: tb/ramp_adc_ctrl_test.sv
module ramp_adc_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0]  res_sel = 2'd0;
  logic [31:0] cmp = '0, pre = '0;
  logic [4:0]  rd_addr = '0;
  logic        ramp_en, done;
  logic [11:0] rd_data;
  int checks = 0, errors = 0;
  int fire_at [32];
  int refire_at [32];

  ramp_adc_ctrl uut (.clk(clk), .rst_n(rst_n), .start_i(start), .res_sel_i(res_sel),
    .cmp_i(cmp), .rd_addr_i(rd_addr), .ramp_en_o(ramp_en), .done_o(done), .rd_data_o(rd_data));

  always #10 clk = ~clk;

  // resolution, channel, count at which that channel fires
  localparam int VEC [6][3] = '{'{0, 0, 0}, '{0, 31, 255}, '{1, 5, 700},
                                '{1, 20, 1023}, '{2, 16, 4095}, '{3, 9, 1234}};

  function automatic int gray(int b); return b ^ (b >> 1); endfunction
  function automatic int width(int r); return r == 0 ? 8 : (r == 1 ? 10 : 12); endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_events();
    for (int i = 0; i < 32; i++) begin fire_at[i] = -1; refire_at[i] = -1; end
    pre = '0;
  endtask

  task automatic run(int res, int restart_at);
    int cnt = 0;
    int n = width(res);
    cmp = pre;
    @(negedge clk);
    res_sel = 2'(res); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 ramp on", int'(ramp_en), 1);
    while (ramp_en && cnt < 5000) begin
      for (int ch = 0; ch < 32; ch++) begin
        if (fire_at[ch] >= 0 && cnt == fire_at[ch]) cmp[ch] = 1'b1;
        else if (fire_at[ch] >= 0 && cnt == fire_at[ch] + 1) cmp[ch] = 1'b0;
        if (refire_at[ch] >= 0 && cnt == refire_at[ch]) cmp[ch] = 1'b1;
      end
      start = (cnt == restart_at);
      if (cnt == 1) begin rd_addr = 5'd31; #1 check("R7 cleared at start", int'(rd_data), 0); end
      cnt++;
      @(negedge clk);
    end
    start = 1'b0; cmp = '0;
    check(restart_at >= 0 ? "R8 length" : "R3 length", cnt, 1 << n);
    check("R3 done high", int'(done), 1);
    for (int ch = 0; ch < 32; ch++) begin
      rd_addr = 5'(ch);
      #1;
      if (fire_at[ch] >= 0) check(refire_at[ch] >= 0 ? "R5 first edge" : "R4 capture",
                                  int'(rd_data), gray(fire_at[ch]));
      else check(pre[ch] ? "R9 pre-high" : "R6 full scale", int'(rd_data), gray((1 << n) - 1));
      check("R7 upper zero", int'(rd_data) >> n, 0);
    end
    @(negedge clk);
    check("R3 done single", int'(done), 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    @(negedge clk);
    check("R1 ramp", int'(ramp_en), 0);
    check("R1 done", int'(done), 0);
    for (int ch = 0; ch < 32; ch++) begin
      rd_addr = 5'(ch); #1 check("R1 result", int'(rd_data), 0);
    end
    for (int v = 0; v < 6; v++) begin
      clear_events();
      fire_at[VEC[v][1]] = VEC[v][2];
      run(VEC[v][0], -1);
    end
    clear_events();
    fire_at[3] = 10; refire_at[3] = 40;
    fire_at[17] = 200; refire_at[17] = 250;
    run(0, -1);
    clear_events();
    fire_at[12] = 300;
    run(1, 100);
    clear_events();
    pre[6] = 1'b1; pre[25] = 1'b1;
    fire_at[7] = 5;
    run(0, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule